// File: doc/BRIEF.md
# BCD Calendar Timekeeper Register File

This block keeps calendar time in packed BCD and exposes it as eight byte-wide locations behind a small synchronous register port. A set of running counters (seconds, minutes, hours, weekday, date, month, year and a century flag) advances on a one-pulse-per-second tick input. Software never touches these counters directly. It reads and writes a second, user-visible set of copies that the block refreshes from the counters after every advance. All copies change in the same clock cycle, so every read sees one moment in time.

A control byte decides how copies and counters interact. A read hold freezes the copies so that software can read a coherent time across several accesses. A write hold also freezes them and opens the time fields for writing. Clearing the write hold moves every loaded copy into the counters in a single cycle. A stop bit in the seconds location halts counting. The weekday location carries a century-enable bit, a century flag and a frequency-test storage bit. The oscillator, the prescaler and the surrounding memory array sit outside this block; the tick input stands in for them.

Top module: `caltk_regfile`

## Requirements
- R1: After reset the control byte reads 0x00, location 1 reads 0x80 (stop set, 0 seconds), minutes and hours read 0x00, location 4 reads 0x01, date and month read 0x01, and year reads RESET_YEAR.
- R2: Bit 7 of location 1 is the stop bit. It can be written at any time, and while it is 1 the tick has no effect on the time.
- R3: Locations are indexed 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month, 7 year, and rd_data shows the addressed location in the same cycle. A tick sampled at clock edge N with stop clear advances the counters at edge N, and all copies take the new time at edge N+1. Seconds and minutes carry at 59 and hours carry at 23.
- R4: A tick at 23:59:59 gives 00:00:00, moves the weekday (bits 2:0 of location 4) up by one with 7 wrapping to 1, and moves the date up by one.
- R5: The date wraps to 01 and the month moves up after day 28 of month 02 in a year not divisible by four, after day 29 of month 02 in a year divisible by four, after day 30 of months 04, 06, 09 and 11, and after day 31 of the other months. After month 12 the month wraps to 01 and the year moves up.
- R6: The year wraps from 99 to 00. On that wrap the century flag (bit 4 of location 4) inverts when century enable (bit 5 of location 4) is 1 and keeps its value when it is 0.
- R7: While control bit 6 (read hold) is 1, the copies keep their values across ticks. After it is cleared, the first later tick refreshes them again.
- R8: While control bit 7 (write hold) is 1, the copies keep their values across ticks and the time fields accept writes. A control write that clears bit 7 while it is set loads all seven time copies and the century flag into the counters, and the next tick advances from the loaded time.
- R9: Without write hold, writes to the time fields and to the century flag leave the copies unchanged. The stop bit, century enable and frequency-test bit (bit 6 of location 4) are written at any time.
- R10: Bits that are not part of a field read as 0: bit 7 of minutes, bits 7:6 of hours and date, bits 7:5 of month, and bits 7 and 3 of location 4.
- R11: Control bits 5:0 are stored as written and read back unchanged, and they do not change the count.
- R12: A refresh that is already under way when read hold gets set still completes: a tick at edge N followed by a control write setting bit 6 at edge N+1 still shows the new time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Writes wr_data into the location at sel on this edge |
| sel | input | 3 | Location index, 0 to 7 |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Contents of the location at sel |

## Verification
The bench builds the block with RESET_STOP left at 1 and RESET_YEAR set to 0x98. Because the clock therefore starts stopped, the stop bit is exercised before any tick can move the time. The non-zero reset year shows that the parameter reaches the year copy and the counters. Every other calendar point the bench needs (month ends in leap and common years, the year 99 rollover with and without century enable, the weekday wrap) is loaded through the write-hold path, so each rollover takes a single tick.

// File: rtl/caltk_pkg.sv
`timescale 1ns/1ps
package caltk_pkg;

    localparam int BYTE_W   = 8;
    localparam int IDX_W    = 3;
    localparam int STOP_BIT = 7;
    localparam int FT_BIT   = 6;
    localparam int CEB_BIT  = 5;
    localparam int CF_BIT   = 4;

    typedef enum logic [IDX_W-1:0] {
        IDX_CTL  = 3'd0,
        IDX_SEC  = 3'd1,
        IDX_MIN  = 3'd2,
        IDX_HR   = 3'd3,
        IDX_DOW  = 3'd4,
        IDX_DATE = 3'd5,
        IDX_MON  = 3'd6,
        IDX_YR   = 3'd7
    } reg_idx_e;

    // Control byte: two hold bits, then calibration sign and magnitude (stored only)
    typedef struct packed {
        logic       wr_hold;
        logic       rd_hold;
        logic       cal_sign;
        logic [4:0] cal_mag;
    } ctl_t;

    // One BCD byte per field, unused upper bits held at zero by the write masks
    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hr;
        logic [BYTE_W-1:0] dow;
        logic [BYTE_W-1:0] date;
        logic [BYTE_W-1:0] mon;
        logic [BYTE_W-1:0] yr;
        logic              cflag;
    } caltime_t;

    typedef struct packed {
        logic [BYTE_W-1:0] val;
        logic              wrap;
    } bcd_step_t;

    function automatic caltime_t init_time(input logic [BYTE_W-1:0] year);
        caltime_t t;
        t.sec   = 8'h00;
        t.min   = 8'h00;
        t.hr    = 8'h00;
        t.dow   = 8'h01;
        t.date  = 8'h01;
        t.mon   = 8'h01;
        t.yr    = year;
        t.cflag = 1'b0;
        return t;
    endfunction

    // Increment a BCD byte; at or past the upper bound return to the lower one
    function automatic bcd_step_t bcd_step(input logic [BYTE_W-1:0] v,
                                           input logic [BYTE_W-1:0] lo,
                                           input logic [BYTE_W-1:0] hi);
        bcd_step_t r;
        if (v >= hi) begin
            r.val  = lo;
            r.wrap = 1'b1;
        end else if (v[3:0] >= 4'd9) begin
            r.val  = {v[7:4] + 4'd1, 4'd0};
            r.wrap = 1'b0;
        end else begin
            r.val  = v + 8'd1;
            r.wrap = 1'b0;
        end
        return r;
    endfunction

    // Divisible by four, tested on the BCD digits without a binary conversion
    function automatic logic bcd_leap(input logic [BYTE_W-1:0] yr);
        logic [3:0] ones;
        ones = yr[3:0];
        if (yr[4])
            return (ones == 4'd2) || (ones == 4'd6);
        else
            return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
    endfunction

    function automatic logic [BYTE_W-1:0] month_last(input logic [BYTE_W-1:0] mon,
                                                     input logic [BYTE_W-1:0] yr);
        case (mon)
            8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/caltk_ctrl.sv
`timescale 1ns/1ps
module caltk_ctrl
    import caltk_pkg::*;
#(
    parameter logic RESET_STOP = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    output ctl_t              ctl,
    output logic              stop,
    output logic              ft,
    output logic              ceb,
    output logic              adv,
    output logic              load,
    output logic              refresh
);

    assign adv  = tick & ~stop;
    // Clearing write hold transfers the copies into the counters
    assign load = wr_en && (wr_idx == IDX_CTL) && ctl.wr_hold && !wr_data[STOP_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '0;
            stop    <= RESET_STOP;
            ft      <= 1'b0;
            ceb     <= 1'b0;
            refresh <= 1'b0;
        end else begin
            // Hold state is taken at the advance; a later hold does not cancel it
            refresh <= adv & ~ctl.wr_hold & ~ctl.rd_hold;
            if (wr_en) begin
                case (wr_idx)
                    IDX_CTL: ctl <= ctl_t'(wr_data);
                    IDX_SEC: stop <= wr_data[STOP_BIT];
                    IDX_DOW: begin
                        ft  <= wr_data[FT_BIT];
                        ceb <= wr_data[CEB_BIT];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/caltk_counters.sv
`timescale 1ns/1ps
module caltk_counters
    import caltk_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RESET_YEAR = 8'h00
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     adv,
    input  logic     load,
    input  caltime_t load_val,
    input  logic     ceb,
    output caltime_t now
);

    bcd_step_t st_sec, st_min, st_hr, st_date, st_mon, st_yr;
    caltime_t  nxt;

    always_comb begin
        st_sec  = bcd_step(now.sec,  8'h00, 8'h59);
        st_min  = bcd_step(now.min,  8'h00, 8'h59);
        st_hr   = bcd_step(now.hr,   8'h00, 8'h23);
        st_date = bcd_step(now.date, 8'h01, month_last(now.mon, now.yr));
        st_mon  = bcd_step(now.mon,  8'h01, 8'h12);
        st_yr   = bcd_step(now.yr,   8'h00, 8'h99);

        nxt     = now;
        nxt.sec = st_sec.val;
        if (st_sec.wrap) begin
            nxt.min = st_min.val;
            if (st_min.wrap) begin
                nxt.hr = st_hr.val;
                if (st_hr.wrap) begin
                    nxt.dow  = (now.dow >= 8'd7) ? 8'd1 : now.dow + 8'd1;
                    nxt.date = st_date.val;
                    if (st_date.wrap) begin
                        nxt.mon = st_mon.val;
                        if (st_mon.wrap) begin
                            nxt.yr = st_yr.val;
                            if (st_yr.wrap && ceb)
                                nxt.cflag = ~now.cflag;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            now <= init_time(RESET_YEAR);
        else if (load)
            now <= load_val;
        else if (adv)
            now <= nxt;
    end

endmodule

// File: rtl/caltk_copies.sv
`timescale 1ns/1ps
module caltk_copies
    import caltk_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RESET_YEAR = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              refresh,
    input  caltime_t          snap,
    input  logic              wr_en,
    input  logic              wr_open,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    output caltime_t          view
);

    always_ff @(posedge clk) begin
        if (rst) begin
            view <= init_time(RESET_YEAR);
        end else begin
            if (refresh)
                view <= snap;
            if (wr_en && wr_open) begin
                case (wr_idx)
                    IDX_SEC:  view.sec  <= {1'b0, wr_data[6:0]};
                    IDX_MIN:  view.min  <= {1'b0, wr_data[6:0]};
                    IDX_HR:   view.hr   <= {2'b0, wr_data[5:0]};
                    IDX_DOW: begin
                        view.dow   <= {5'b0, wr_data[2:0]};
                        view.cflag <= wr_data[CF_BIT];
                    end
                    IDX_DATE: view.date <= {2'b0, wr_data[5:0]};
                    IDX_MON:  view.mon  <= {3'b0, wr_data[4:0]};
                    IDX_YR:   view.yr   <= wr_data;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/caltk_regfile.sv
`timescale 1ns/1ps
module caltk_regfile
    import caltk_pkg::*;
#(
    parameter logic              RESET_STOP = 1'b1,
    parameter logic [BYTE_W-1:0] RESET_YEAR = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data
);

    ctl_t     ctl_q;
    logic     stop_q, ft_q, ceb_q;
    logic     adv, load, refresh;
    caltime_t cnt_now, copy_view;

    caltk_ctrl #(.RESET_STOP(RESET_STOP)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_1hz),
        .wr_en   (wr_en),
        .wr_idx  (sel),
        .wr_data (wr_data),
        .ctl     (ctl_q),
        .stop    (stop_q),
        .ft      (ft_q),
        .ceb     (ceb_q),
        .adv     (adv),
        .load    (load),
        .refresh (refresh)
    );

    caltk_counters #(.RESET_YEAR(RESET_YEAR)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .load     (load),
        .load_val (copy_view),
        .ceb      (ceb_q),
        .now      (cnt_now)
    );

    caltk_copies #(.RESET_YEAR(RESET_YEAR)) u_copy (
        .clk     (clk),
        .rst     (rst),
        .refresh (refresh),
        .snap    (cnt_now),
        .wr_en   (wr_en),
        .wr_open (ctl_q.wr_hold),
        .wr_idx  (sel),
        .wr_data (wr_data),
        .view    (copy_view)
    );

    always_comb begin
        case (sel)
            IDX_CTL:  rd_data = ctl_q;
            IDX_SEC:  rd_data = {stop_q, copy_view.sec[6:0]};
            IDX_MIN:  rd_data = {1'b0, copy_view.min[6:0]};
            IDX_HR:   rd_data = {2'b0, copy_view.hr[5:0]};
            IDX_DOW:  rd_data = {1'b0, ft_q, ceb_q, copy_view.cflag, 1'b0, copy_view.dow[2:0]};
            IDX_DATE: rd_data = {2'b0, copy_view.date[5:0]};
            IDX_MON:  rd_data = {3'b0, copy_view.mon[4:0]};
            default:  rd_data = copy_view.yr;
        endcase
    end

endmodule

// File: rtl/caltk_checker.sv
`timescale 1ns/1ps
module caltk_checker
    import caltk_pkg::*;
#(
    parameter logic RESET_STOP = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [IDX_W-1:0]  sel,
    input logic [BYTE_W-1:0] rd_data,
    input ctl_t              ctl,
    input logic              stop,
    input logic              ceb,
    input logic              load,
    input logic              refresh,
    input caltime_t          cnt,
    input caltime_t          view
);

    // R1: reset leaves the control byte clear and the stop bit at its reset value
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ctl == '0 && stop == RESET_STOP));

    // R2: stopped counters do not move unless loaded
    a_r2_stop_freezes: assert property (@(posedge clk) disable iff (rst)
        (stop && !load) |=> $stable(cnt));

    // R3: a refresh copies the whole counter set in one edge
    a_r3_refresh_copies: assert property (@(posedge clk) disable iff (rst)
        (refresh && !wr_en) |=> (view == $past(cnt)));

    // R7: read hold keeps the copies when no refresh is pending and writes are closed
    a_r7_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        (ctl.rd_hold && !refresh && !(wr_en && ctl.wr_hold)) |=> $stable(view));

    // R8: releasing write hold transfers every copy into the counters
    a_r8_release_loads: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(view)));

    // R6: with century enable clear the flag is only changed by a load
    a_r6_century_kept: assert property (@(posedge clk) disable iff (rst)
        (!ceb && !load) |=> $stable(cnt.cflag));

    // R10: unused bits of hours and date read zero
    a_r10_zero_bits: assert property (@(posedge clk) disable iff (rst)
        (sel == IDX_HR || sel == IDX_DATE) |-> ((rd_data & 8'hC0) == 8'h00));

endmodule

bind caltk_regfile caltk_checker #(.RESET_STOP(RESET_STOP)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .sel     (sel),
    .rd_data (rd_data),
    .ctl     (ctl_q),
    .stop    (stop_q),
    .ceb     (ceb_q),
    .load    (load),
    .refresh (refresh),
    .cnt     (cnt_now),
    .view    (copy_view)
);

// File: tb/caltk_regfile_tb.sv
`timescale 1ns/1ps
module caltk_regfile_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       we = 1'b0;
    logic [2:0] sel = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    caltk_regfile #(.RESET_STOP(1'b1), .RESET_YEAR(8'h98)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .tick_1hz (tick),
        .wr_en    (we),
        .sel      (sel),
        .wr_data  (wdata),
        .rd_data  (rdata)
    );

    // Behavioural reference: decimal integers, index 0 sec .. 6 year, 7 century flag
    int   kc[8];
    int   vc[8];
    int   ks[8];
    int   vs[8];
    logic [7:0] m_ctl;
    bit   m_stop, m_ft, m_ceb, m_pend;
    bit   t_wh, t_rh, t_run, t_ld;

    function automatic int b2i(input logic [7:0] x);
        return int'(x[7:4]) * 10 + int'(x[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic int days_in(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] mview(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0: return m_ctl;
            3'd1: begin b = i2b(vc[0]); return {m_stop, b[6:0]}; end
            3'd2: return i2b(vc[1]);
            3'd3: return i2b(vc[2]);
            3'd4: return {1'b0, m_ft, m_ceb, 1'(vc[7]), 1'b0, 3'(vc[3])};
            3'd5: return i2b(vc[4]);
            3'd6: return i2b(vc[5]);
            default: return i2b(vc[6]);
        endcase
    endfunction

    task automatic model_advance();
        kc[0]++;
        if (kc[0] == 60) begin
            kc[0] = 0; kc[1]++;
            if (kc[1] == 60) begin
                kc[1] = 0; kc[2]++;
                if (kc[2] == 24) begin
                    kc[2] = 0;
                    kc[3] = (kc[3] == 7) ? 1 : kc[3] + 1;
                    kc[4]++;
                    if (kc[4] > days_in(kc[5], kc[6])) begin
                        kc[4] = 1; kc[5]++;
                        if (kc[5] == 13) begin
                            kc[5] = 1; kc[6]++;
                            if (kc[6] == 100) begin
                                kc[6] = 0;
                                if (m_ceb) kc[7] = 1 - kc[7];
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic model_write();
        case (sel)
            3'd0: m_ctl = wdata;
            3'd1: begin m_stop = wdata[7]; if (t_wh) vc[0] = b2i({1'b0, wdata[6:0]}); end
            3'd2: if (t_wh) vc[1] = b2i({1'b0, wdata[6:0]});
            3'd3: if (t_wh) vc[2] = b2i({2'b0, wdata[5:0]});
            3'd4: begin
                m_ft = wdata[6];
                m_ceb = wdata[5];
                if (t_wh) begin vc[7] = int'(wdata[4]); vc[3] = int'(wdata[2:0]); end
            end
            3'd5: if (t_wh) vc[4] = b2i({2'b0, wdata[5:0]});
            3'd6: if (t_wh) vc[5] = b2i({3'b0, wdata[4:0]});
            default: if (t_wh) vc[6] = b2i(wdata);
        endcase
    endtask

    always @(posedge clk) begin
        if (rst) begin
            kc = '{0, 0, 0, 1, 1, 1, 98, 0};
            vc = kc;
            m_ctl = 8'h00; m_stop = 1'b1; m_ft = 1'b0; m_ceb = 1'b0; m_pend = 1'b0;
        end else begin
            t_wh  = m_ctl[7];
            t_rh  = m_ctl[6];
            t_run = tick && !m_stop;
            t_ld  = we && (sel == 3'd0) && t_wh && !wdata[7];
            ks = kc;
            vs = vc;
            if (t_ld) kc = vs;
            else if (t_run) model_advance();
            if (m_pend) vc = ks;
            if (we) model_write();
            m_pend = t_run && !t_wh && !t_rh;
        end
    end

    // Every-clock comparison of the addressed location against the model (R3)
    always @(negedge clk) begin
        if (!rst && !finished) begin
            n_vec++;
            if (rdata !== mview(sel)) begin
                n_bad++;
                $display("FAIL R3 model compare sel=%0d actual=%02h expected=%02h",
                         sel, rdata, mview(sel));
            end
        end
    end

    task automatic chk(input string req, input logic [2:0] idx, input logic [7:0] exp);
        sel = idx;
        @(negedge clk);
        n_vec++;
        if (rdata !== exp) begin
            n_bad++;
            $display("FAIL %s loc=%0d actual=%02h expected=%02h", req, idx, rdata, exp);
        end
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] idx, input logic [7:0] d);
        sel = idx; wdata = d; we = 1'b1;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic pulse();
        tick = 1'b1;
        @(posedge clk); #1;
        tick = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                            input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                            input logic [7:0] y);
        wr(3'd0, 8'h80);
        wr(3'd1, s); wr(3'd2, mi); wr(3'd3, h); wr(3'd4, dw);
        wr(3'd5, dt); wr(3'd6, mo); wr(3'd7, y);
        wr(3'd0, 8'h00);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1 reset values
        chk("R1", 3'd0, 8'h00); chk("R1", 3'd1, 8'h80); chk("R1", 3'd2, 8'h00);
        chk("R1", 3'd3, 8'h00); chk("R1", 3'd4, 8'h01); chk("R1", 3'd5, 8'h01);
        chk("R1", 3'd6, 8'h01); chk("R1", 3'd7, 8'h98);

        // R2 stopped clock ignores ticks
        pulse(); pulse(); pulse();
        chk("R2", 3'd1, 8'h80);
        wr(3'd1, 8'h00);
        chk("R2", 3'd1, 8'h00);

        // R9 time fields closed without write hold; control bits open
        wr(3'd2, 8'h30);
        chk("R9", 3'd2, 8'h00);
        wr(3'd4, 8'h71);
        chk("R9", 3'd4, 8'h61);

        // R3 seconds advance
        pulse(); chk("R3", 3'd1, 8'h01);
        pulse(); chk("R3", 3'd1, 8'h02);

        // R11 calibration bits stored only
        wr(3'd0, 8'h3A);
        chk("R11", 3'd0, 8'h3A);
        pulse(); chk("R11", 3'd1, 8'h03);

        // R8 write hold: frozen, load, release
        wr(3'd0, 8'h80);
        pulse(); chk("R8", 3'd1, 8'h03);
        wr(3'd1, 8'h58); wr(3'd2, 8'h59); wr(3'd3, 8'h23); wr(3'd4, 8'h27);
        wr(3'd5, 8'h31); wr(3'd6, 8'h12); wr(3'd7, 8'h99);
        chk("R8", 3'd1, 8'h58);
        wr(3'd0, 8'h00);
        chk("R8", 3'd1, 8'h58);
        pulse(); chk("R8", 3'd1, 8'h59);

        // R4 R5 R6 full rollover, century enable set
        pulse();
        chk("R4", 3'd1, 8'h00); chk("R4", 3'd2, 8'h00); chk("R4", 3'd3, 8'h00);
        chk("R6", 3'd4, 8'h31); chk("R4", 3'd5, 8'h01); chk("R5", 3'd6, 8'h01);
        chk("R6", 3'd7, 8'h00);

        // R6 century enable clear: flag kept
        set_time(8'h59, 8'h59, 8'h23, 8'h16, 8'h31, 8'h12, 8'h99);
        pulse();
        chk("R6", 3'd7, 8'h00); chk("R6", 3'd4, 8'h17);

        // R5 month ends
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
        pulse(); chk("R5", 3'd5, 8'h01); chk("R5", 3'd6, 8'h03); chk("R4", 3'd4, 8'h04);
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
        pulse(); chk("R5", 3'd5, 8'h29); chk("R5", 3'd6, 8'h02);
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
        pulse(); chk("R5", 3'd5, 8'h01); chk("R5", 3'd6, 8'h03);
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h24);
        pulse(); chk("R5", 3'd5, 8'h01); chk("R5", 3'd6, 8'h05);
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h05, 8'h24);
        pulse(); chk("R5", 3'd5, 8'h31); chk("R5", 3'd6, 8'h05);

        // R7 read hold
        wr(3'd0, 8'h40);
        pulse(); pulse();
        chk("R7", 3'd1, 8'h00);
        wr(3'd0, 8'h00);
        chk("R7", 3'd1, 8'h00);
        pulse(); chk("R7", 3'd1, 8'h03);

        // R12 refresh in flight completes despite a new read hold
        tick = 1'b1;
        @(posedge clk); #1;
        tick = 1'b0;
        wr(3'd0, 8'h40);
        chk("R12", 3'd1, 8'h04);
        pulse(); chk("R12", 3'd1, 8'h04);
        wr(3'd0, 8'h00);

        // R10 zero bits
        wr(3'd0, 8'h80);
        wr(3'd3, 8'hD5); wr(3'd2, 8'hC2); wr(3'd5, 8'hC9); wr(3'd6, 8'hE7); wr(3'd4, 8'h8B);
        chk("R10", 3'd3, 8'h15); chk("R10", 3'd2, 8'h42); chk("R10", 3'd5, 8'h09);
        chk("R10", 3'd6, 8'h07); chk("R10", 3'd4, 8'h03);
        wr(3'd0, 8'h00);

        repeat (2) @(posedge clk);
        #1;
        finish_run();
    end

endmodule